// File: doc/BRIEF.md
# Pad Standby Drive Override

This block sits between the functional pad logic of a group of I/O pads and the pads themselves. In normal operation it passes the functional transmit value, transmit enable, receive enable, received value and pull request straight through. When the shared standby request is raised, each pad switches to a substitute behaviour chosen by its own 4-bit standby code, and to a pull setting chosen by its own 2-bit standby termination code. The override stays in place for as long as the request is held.

The substitutes are: freeze the drive state seen at entry, drive a fixed level with the receiver either off or on, float the pad, or keep only the receiver on for wake sensing. A pad can also opt out of standby altogether. Where the receiver is switched off, a constant replaces the received value on the core side, so that downstream logic sees a defined level. The codes and the termination are sampled once, at entry, and held through the standby period.

Top module: `pad_stby_ovr`

## Requirements
- R1: While no standby is registered, every pad passes func_tx, func_txen and func_rxen to pad_tx, pad_txen and pad_rxen, core_rx equals pad_rx, and pulls follow func_pu/func_pd in the same cycle.
- R2: Standby takes effect from the first rising clock edge at which stby_req is sampled 1 and ends at the first edge at which it is sampled 0. The codes and termination of each pad are sampled at that entry edge, and changes to them during standby have no effect.
- R3: Code 0 drives pad_tx, pad_txen and pad_rxen with the func_tx, func_txen and func_rxen values sampled at the entry edge for the whole standby period; core_rx follows pad_rx.
- R4: Codes 1, 2, 3, 4 set pad_txen=1 and pad_rxen=0, with (pad_tx, core_rx) = (0,0), (0,1), (1,0), (1,1) in that order.
- R5: Codes 5 and 6 set pad_txen=1, pad_rxen=1 and pad_tx=0 or 1 respectively, with core_rx following pad_rx.
- R6: Codes 7 and 8 set pad_txen=0, pad_rxen=0, pad_tx=0, and core_rx=0 or 1 respectively.
- R7: Code 9 sets pad_txen=0, pad_tx=0, pad_rxen=1, and core_rx follows pad_rx.
- R8: Code 15 and the unassigned codes 10 to 14 exclude the pad from standby: all of its outputs, pulls included, behave as in R1.
- R9: In standby with a non-masked code, termination code 0 keeps the functional pull, 1 turns both pulls off, 2 turns on only pad_pd, and 3 turns on only pad_pu.
- R10: pad_pu and pad_pd are never both 1; a functional request with both func_pu and func_pd set gives neither.
- R11: Pad i takes its code from stby_code[4i+3:4i] and its termination from stby_term[2i+1:2i], independently of the other pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby request shared by all pads |
| stby_code | input | 4*NPAD | Per-pad standby state code, pad i at bits 4i+3:4i |
| stby_term | input | 2*NPAD | Per-pad standby termination, pad i at bits 2i+1:2i |
| func_tx | input | NPAD | Functional transmit value |
| func_txen | input | NPAD | Functional transmit enable |
| func_rxen | input | NPAD | Functional receive enable |
| func_pu | input | NPAD | Functional pull-up request |
| func_pd | input | NPAD | Functional pull-down request |
| pad_rx | input | NPAD | Value received from the pad |
| pad_tx | output | NPAD | Effective transmit value to the pad |
| pad_txen | output | NPAD | Effective transmit enable |
| pad_rxen | output | NPAD | Effective receive enable |
| core_rx | output | NPAD | Received value handed to the core |
| pad_pu | output | NPAD | Pull-up enable |
| pad_pd | output | NPAD | Pull-down enable |

## Verification
The bench goes after the entry and exit edges: a design that applied the override combinationally would switch a cycle early, and one that sampled the code continuously would follow code changes made mid-standby instead of holding. It checks that the freeze code keeps the entry-edge values while the functional inputs keep changing, which a transparent latch would fail, and that codes 10 to 14 fall back to pass-through rather than to some drive state. It also drives conflicting functional pulls and mixes different codes across pads in one standby period, catching a pull stage that lets both enables through and slice wiring that picks up a neighbour's code.

// File: rtl/pad_stby_pkg.sv
package pad_stby_pkg;

  localparam int CODE_W = 4;
  localparam int TERM_W = 2;

  typedef enum logic [CODE_W-1:0] {
    SC_FREEZE   = 4'd0,
    SC_L_RX0    = 4'd1,
    SC_L_RX1    = 4'd2,
    SC_H_RX0    = 4'd3,
    SC_H_RX1    = 4'd4,
    SC_L_RXON   = 4'd5,
    SC_H_RXON   = 4'd6,
    SC_FLOAT0   = 4'd7,
    SC_FLOAT1   = 4'd8,
    SC_WAKE     = 4'd9,
    SC_OPTOUT   = 4'd15
  } stby_code_e;

  typedef enum logic [TERM_W-1:0] {
    TM_KEEP = 2'd0,
    TM_NONE = 2'd1,
    TM_DOWN = 2'd2,
    TM_UP   = 2'd3
  } stby_term_e;

  // Substitute drive produced by the code decoder.
  typedef struct packed {
    logic tx;
    logic txen;
    logic rxen;
    logic rx_force;
    logic rx_val;
  } drive_t;

endpackage

// File: rtl/stby_rst_sync.sv
module stby_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/stby_decode.sv
module stby_decode
  import pad_stby_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output drive_t            ovr,
  output logic              use_freeze,
  output logic              opt_out
);

  always_comb begin
    ovr        = '0;
    use_freeze = 1'b0;
    opt_out    = 1'b0;
    case (code)
      SC_FREEZE: use_freeze = 1'b1;
      SC_L_RX0:  ovr = '{tx: 1'b0, txen: 1'b1, rxen: 1'b0, rx_force: 1'b1, rx_val: 1'b0};
      SC_L_RX1:  ovr = '{tx: 1'b0, txen: 1'b1, rxen: 1'b0, rx_force: 1'b1, rx_val: 1'b1};
      SC_H_RX0:  ovr = '{tx: 1'b1, txen: 1'b1, rxen: 1'b0, rx_force: 1'b1, rx_val: 1'b0};
      SC_H_RX1:  ovr = '{tx: 1'b1, txen: 1'b1, rxen: 1'b0, rx_force: 1'b1, rx_val: 1'b1};
      SC_L_RXON: ovr = '{tx: 1'b0, txen: 1'b1, rxen: 1'b1, rx_force: 1'b0, rx_val: 1'b0};
      SC_H_RXON: ovr = '{tx: 1'b1, txen: 1'b1, rxen: 1'b1, rx_force: 1'b0, rx_val: 1'b0};
      SC_FLOAT0: ovr = '{tx: 1'b0, txen: 1'b0, rxen: 1'b0, rx_force: 1'b1, rx_val: 1'b0};
      SC_FLOAT1: ovr = '{tx: 1'b0, txen: 1'b0, rxen: 1'b0, rx_force: 1'b1, rx_val: 1'b1};
      SC_WAKE:   ovr = '{tx: 1'b0, txen: 1'b0, rxen: 1'b1, rx_force: 1'b0, rx_val: 1'b0};
      default:   opt_out = 1'b1;   // 10..15: pad stays functional
    endcase
  end

endmodule

// File: rtl/stby_pull.sv
module stby_pull
  import pad_stby_pkg::*;
(
  input  logic              active,
  input  logic [TERM_W-1:0] term,
  input  logic              req_up,
  input  logic              req_dn,
  output logic              pu,
  output logic              pd
);

  logic func_up;
  logic func_dn;

  // Conflicting functional request resolves to no pull.
  always_comb begin
    func_up = req_up & ~req_dn;
    func_dn = req_dn & ~req_up;
  end

  always_comb begin
    pu = func_up;
    pd = func_dn;
    if (active) begin
      case (term)
        TM_NONE: begin pu = 1'b0; pd = 1'b0; end
        TM_DOWN: begin pu = 1'b0; pd = 1'b1; end
        TM_UP:   begin pu = 1'b1; pd = 1'b0; end
        default: begin pu = func_up; pd = func_dn; end
      endcase
    end
  end

endmodule

// File: rtl/stby_slice.sv
module stby_slice
  import pad_stby_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stby,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic [TERM_W-1:0] term_in,
  input  logic              f_tx,
  input  logic              f_txen,
  input  logic              f_rxen,
  input  logic              f_pu,
  input  logic              f_pd,
  input  logic              rx_in,
  output logic              o_tx,
  output logic              o_txen,
  output logic              o_rxen,
  output logic              o_rx,
  output logic              o_pu,
  output logic              o_pd,
  output logic [CODE_W-1:0] code_held
);

  logic [CODE_W-1:0] code_q, code_d;
  logic [TERM_W-1:0] term_q, term_d;
  logic              frz_tx_q, frz_tx_d;
  logic              frz_txen_q, frz_txen_d;
  logic              frz_rxen_q, frz_rxen_d;

  drive_t ovr;
  logic   use_freeze;
  logic   opt_out;
  logic   active;

  // Next state: load on the entry edge only.
  always_comb begin
    code_d     = code_q;
    term_d     = term_q;
    frz_tx_d   = frz_tx_q;
    frz_txen_d = frz_txen_q;
    frz_rxen_d = frz_rxen_q;
    if (capture) begin
      code_d     = code_in;
      term_d     = term_in;
      frz_tx_d   = f_tx;
      frz_txen_d = f_txen;
      frz_rxen_d = f_rxen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q     <= SC_OPTOUT;
      term_q     <= TM_KEEP;
      frz_tx_q   <= 1'b0;
      frz_txen_q <= 1'b0;
      frz_rxen_q <= 1'b0;
    end else begin
      code_q     <= code_d;
      term_q     <= term_d;
      frz_tx_q   <= frz_tx_d;
      frz_txen_q <= frz_txen_d;
      frz_rxen_q <= frz_rxen_d;
    end
  end

  stby_decode u_dec (
    .code       (code_q),
    .ovr        (ovr),
    .use_freeze (use_freeze),
    .opt_out    (opt_out)
  );

  assign active = in_stby & ~opt_out;

  always_comb begin
    o_tx   = f_tx;
    o_txen = f_txen;
    o_rxen = f_rxen;
    o_rx   = rx_in;
    if (active) begin
      if (use_freeze) begin
        o_tx   = frz_tx_q;
        o_txen = frz_txen_q;
        o_rxen = frz_rxen_q;
      end else begin
        o_tx   = ovr.tx;
        o_txen = ovr.txen;
        o_rxen = ovr.rxen;
        o_rx   = ovr.rx_force ? ovr.rx_val : rx_in;
      end
    end
  end

  stby_pull u_pull (
    .active (active),
    .term   (term_q),
    .req_up (f_pu),
    .req_dn (f_pd),
    .pu     (o_pu),
    .pd     (o_pd)
  );

  assign code_held = code_q;

endmodule

// File: rtl/pad_stby_ovr.sv
module pad_stby_ovr
  import pad_stby_pkg::*;
#(
  parameter int NPAD = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stby_req,
  input  logic [NPAD*CODE_W-1:0] stby_code,
  input  logic [NPAD*TERM_W-1:0] stby_term,
  input  logic [NPAD-1:0]        func_tx,
  input  logic [NPAD-1:0]        func_txen,
  input  logic [NPAD-1:0]        func_rxen,
  input  logic [NPAD-1:0]        func_pu,
  input  logic [NPAD-1:0]        func_pd,
  input  logic [NPAD-1:0]        pad_rx,
  output logic [NPAD-1:0]        pad_tx,
  output logic [NPAD-1:0]        pad_txen,
  output logic [NPAD-1:0]        pad_rxen,
  output logic [NPAD-1:0]        core_rx,
  output logic [NPAD-1:0]        pad_pu,
  output logic [NPAD-1:0]        pad_pd
);

  localparam int CODE_BUS = NPAD * CODE_W;

  logic                rst_n_int;
  logic                req_q, req_d;
  logic                entry;
  logic [CODE_BUS-1:0] code_hold;

  stby_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    req_d = stby_req;
    entry = stby_req & ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) req_q <= 1'b0;
    else            req_q <= req_d;
  end

  for (genvar g = 0; g < NPAD; g++) begin : g_pad
    stby_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .in_stby   (req_q),
      .capture   (entry),
      .code_in   (stby_code[g*CODE_W +: CODE_W]),
      .term_in   (stby_term[g*TERM_W +: TERM_W]),
      .f_tx      (func_tx[g]),
      .f_txen    (func_txen[g]),
      .f_rxen    (func_rxen[g]),
      .f_pu      (func_pu[g]),
      .f_pd      (func_pd[g]),
      .rx_in     (pad_rx[g]),
      .o_tx      (pad_tx[g]),
      .o_txen    (pad_txen[g]),
      .o_rxen    (pad_rxen[g]),
      .o_rx      (core_rx[g]),
      .o_pu      (pad_pu[g]),
      .o_pd      (pad_pd[g]),
      .code_held (code_hold[g*CODE_W +: CODE_W])
    );
  end

endmodule

// File: rtl/stby_chk.sv
module stby_chk #(
  parameter int NPAD = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_hold,
  input logic [NPAD*4-1:0] code_hold,
  input logic [NPAD-1:0]   func_tx,
  input logic [NPAD-1:0]   func_txen,
  input logic [NPAD-1:0]   pad_rx,
  input logic [NPAD-1:0]   pad_tx,
  input logic [NPAD-1:0]   pad_txen,
  input logic [NPAD-1:0]   pad_rxen,
  input logic [NPAD-1:0]   core_rx,
  input logic [NPAD-1:0]   pad_pu,
  input logic [NPAD-1:0]   pad_pd
);

  for (genvar i = 0; i < NPAD; i++) begin : g_chk
    logic [3:0] c;
    assign c = code_hold[i*4 +: 4];

    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_hold |-> (pad_tx[i] == func_tx[i] && pad_txen[i] == func_txen[i] && core_rx[i] == pad_rx[i]));

    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hold && $past(req_hold) && c == 4'd0) |-> ($stable(pad_tx[i]) && $stable(pad_txen[i]) && $stable(pad_rxen[i])));

    // R4 and R5: fixed-drive codes enable the driver at the code's level.
    p_drive_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hold && c >= 4'd1 && c <= 4'd6) |-> (pad_txen[i] && pad_tx[i] == (c == 4'd3 || c == 4'd4 || c == 4'd6)));

    p_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hold && (c == 4'd7 || c == 4'd8)) |-> (!pad_txen[i] && !pad_rxen[i] && core_rx[i] == (c == 4'd8)));

    p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hold && c == 4'd9) |-> (!pad_txen[i] && pad_rxen[i] && core_rx[i] == pad_rx[i]));

    p_optout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_hold && c >= 4'd10) |-> (pad_tx[i] == func_tx[i] && pad_txen[i] == func_txen[i] && core_rx[i] == pad_rx[i]));

    p_pull_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[i] && pad_pd[i]));
  end

endmodule

bind pad_stby_ovr stby_chk #(.NPAD(NPAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_hold  (req_q),
  .code_hold (code_hold),
  .func_tx   (func_tx),
  .func_txen (func_txen),
  .pad_rx    (pad_rx),
  .pad_tx    (pad_tx),
  .pad_txen  (pad_txen),
  .pad_rxen  (pad_rxen),
  .core_rx   (core_rx),
  .pad_pu    (pad_pu),
  .pad_pd    (pad_pd)
);

// File: tb/pad_stby_ovr_tb_top.sv
`timescale 1ns/1ps
module pad_stby_ovr_tb_top;

  localparam int NPAD = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              stby_req;
  logic [NPAD*4-1:0] stby_code;
  logic [NPAD*2-1:0] stby_term;
  logic [NPAD-1:0]   func_tx, func_txen, func_rxen, func_pu, func_pd, pad_rx;
  logic [NPAD-1:0]   pad_tx, pad_txen, pad_rxen, core_rx, pad_pu, pad_pd;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  string force_tag = "";

  // Bench model state
  bit       m_req;
  bit [3:0] m_code [NPAD];
  bit [1:0] m_term [NPAD];
  bit       m_ltx  [NPAD];
  bit       m_ltxen[NPAD];
  bit       m_lrxen[NPAD];

  always #2.5 clk = ~clk;

  pad_stby_ovr #(.NPAD(NPAD)) dut_i (.*);

  // Returns {tx, txen, rxen, rx, pu, pd}
  function automatic logic [5:0] expect_pad(bit act, bit [3:0] c, bit [1:0] t,
      bit ftx, bit ftxen, bit frxen, bit prx, bit fpu, bit fpd, bit ltx, bit ltxen, bit lrxen);
    bit tx = ftx, txen = ftxen, rxen = frxen, rx = prx;
    bit pu = fpu & ~fpd, pd = fpd & ~fpu;
    if (act && c <= 4'd9) begin
      if (c == 0) begin tx = ltx; txen = ltxen; rxen = lrxen; end
      else if (c <= 4) begin tx = (c >= 3); txen = 1; rxen = 0; rx = (c == 2 || c == 4); end
      else if (c <= 6) begin tx = (c == 6); txen = 1; rxen = 1; end
      else if (c <= 8) begin tx = 0; txen = 0; rxen = 0; rx = (c == 8); end
      else begin tx = 0; txen = 0; rxen = 1; end
      case (t)
        2'd1: begin pu = 0; pd = 0; end
        2'd2: begin pu = 0; pd = 1; end
        2'd3: begin pu = 1; pd = 0; end
        default: ;
      endcase
    end
    return {tx, txen, rxen, rx, pu, pd};
  endfunction

  function automatic string tag_for(bit act, bit [3:0] c, bit [1:0] t, bit fpu, bit fpd);
    if (!act)         return (fpu && fpd) ? "R10" : "R1";
    if (c >= 10)      return "R8";
    if (t != 0)       return "R9";
    if (c == 0)       return "R3";
    if (c <= 4)       return "R4";
    if (c <= 6)       return "R5";
    if (c <= 8)       return "R6";
    return "R7";
  endfunction

  task automatic check_all();
    for (int i = 0; i < NPAD; i++) begin
      logic [5:0] exp_v, act_v;
      string tg;
      exp_v = expect_pad(m_req, m_code[i], m_term[i], func_tx[i], func_txen[i], func_rxen[i],
                         pad_rx[i], func_pu[i], func_pd[i], m_ltx[i], m_ltxen[i], m_lrxen[i]);
      act_v = {pad_tx[i], pad_txen[i], pad_rxen[i], core_rx[i], pad_pu[i], pad_pd[i]};
      tg = (force_tag != "") ? force_tag : tag_for(m_req, m_code[i], m_term[i], func_pu[i], func_pd[i]);
      n_run++;
      if (act_v !== exp_v) begin
        n_fail++;
        $display("FAIL %s pad %0d: {tx,txen,rxen,rx,pu,pd} actual %b expected %b", tg, i, act_v, exp_v);
      end
    end
  endtask

  // Check at mid-cycle, then let one edge pass and update the model.
  task automatic cycle();
    #1;
    check_all();
    @(posedge clk);
    if (stby_req && !m_req) begin
      for (int i = 0; i < NPAD; i++) begin
        m_code[i]  = stby_code[i*4 +: 4];
        m_term[i]  = stby_term[i*2 +: 2];
        m_ltx[i]   = func_tx[i];
        m_ltxen[i] = func_txen[i];
        m_lrxen[i] = func_rxen[i];
      end
    end
    m_req = stby_req;
    @(negedge clk);
  endtask

  task automatic rand_func();
    func_tx   = NPAD'($urandom);
    func_txen = NPAD'($urandom);
    func_rxen = NPAD'($urandom);
    func_pu   = NPAD'($urandom);
    func_pd   = NPAD'($urandom);
    pad_rx    = NPAD'($urandom);
  endtask

  // Enter standby with given codes, hold len cycles while codes churn, then leave.
  task automatic standby_run(logic [NPAD*4-1:0] codes, logic [NPAD*2-1:0] terms, int len);
    stby_code = codes;
    stby_term = terms;
    stby_req  = 1'b1;
    rand_func();
    force_tag = "R2";   // request seen but not yet clocked: still functional
    cycle();
    force_tag = "";
    for (int k = 0; k < len; k++) begin
      rand_func();
      stby_code = ($urandom_range(0, 1) != 0) ? (NPAD*4)'($urandom) : codes;  // R2: ignored
      stby_term = (NPAD*2)'($urandom);
      cycle();
    end
    stby_req = 1'b0;
    rand_func();
    force_tag = "R2";   // drop seen but not yet clocked: still in standby
    cycle();
    force_tag = "";
    rand_func();
    cycle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_req = 0;
    for (int i = 0; i < NPAD; i++) begin
      m_code[i] = 4'd15; m_term[i] = 0; m_ltx[i] = 0; m_ltxen[i] = 0; m_lrxen[i] = 0;
    end
    rst_n = 1'b0;
    stby_req = 1'b0;
    stby_code = '1;
    stby_term = '0;
    rand_func();
    @(negedge clk);
    force_tag = "R1";   // reset state: pass-through
    #1; check_all();
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin rand_func(); cycle(); end
    force_tag = "";

    // R10: conflicting functional pulls give no pull
    func_pu = '1; func_pd = '1;
    cycle();

    // Each code on every pad, each termination (R3..R9)
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 4; t++) begin
        standby_run({NPAD{4'(c)}}, {NPAD{2'(t)}}, 3);
      end
    end

    // R11: distinct codes per pad in the same standby period
    standby_run({4'd9, 4'd3, 4'd0, 4'd12}, {2'd3, 2'd2, 2'd1, 2'd0}, 6);
    standby_run({4'd8, 4'd15, 4'd6, 4'd2}, {2'd0, 2'd3, 2'd2, 2'd1}, 6);

    // R3: freeze holds through a long period with churning inputs
    standby_run({NPAD{4'd0}}, {NPAD{2'd0}}, 20);

    // Constrained random mix
    for (int k = 0; k < 3000; k++) begin
      rand_func();
      if ($urandom_range(0, 7) == 0) stby_req = ~stby_req;
      stby_code = (NPAD*4)'($urandom);
      stby_term = (NPAD*2)'($urandom);
      cycle();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule